// File: doc/BRIEF.md
# One-Time Lock Register Command Mode

This block guards a three-bit lock register whose bits can be programmed once and never cleared. The three bits are a secure-sector protect flag, a lock that fixes the device in persistent protection mode, and a lock that fixes it in password protection mode. A host opens the command mode with a three-write unlock sequence. Inside the mode it can read the register or program it. It then leaves the mode with an exit command. While the mode is open, the main array is fenced off through a single enable output.

The register bits stand in for non-volatile cells, so only the power-on reset `por` clears them. The hardware reset `rst_hw` returns the command logic to normal operation and keeps the bits. A program request that would set both mode-lock bits at once is refused and raises an abort flag. A write in the mode that is not a recognised command is taken as an attempt to reach the main array while the mode is still open. It hangs the block until `rst_hw` is asserted.

Top module: `lk_lockreg_cmd`

## Requirements
- R1: The mode opens after three consecutive writes: address 0x555 with data 0xAA, then address 0x2AA with data 0x55, then address 0x555 with data 0x40. `array_en` is low from the cycle after the third write. If a write breaks the order, the sequence restarts.
- R2: `array_en` is high only in normal operation. It is low whenever the mode is open, while the block is programming, and while it is hung.
- R3: A write of data 0x90 inside the mode closes it and brings `array_en` back high on the next cycle.
- R4: A write of data 0xA0 inside the mode arms a program operation, and the next write supplies the data. Data bit 0 is secure-sector protect, bit 1 is persistent-mode lock and bit 2 is password-mode lock. `busy` is then high for PROG_CYCLES cycles. When it falls, each bit written as 1 is set in the register.
- R5: A bit that is set stays set: programming 0 into it leaves it at 1. Only `por` clears the register.
- R6: If program data has bits 1 and 2 both at 1, no bit changes and `busy` stays low. `abort` rises on the next cycle, and the mode stays open.
- R7: `abort` stays high until the next accepted command: a completed unlock sequence, a 0xA0 write or a 0x90 write. Reads do not clear it.
- R8: A read strobe in the open mode, with no write in the same cycle and no other read pending, gives a one-cycle `rdata_valid` pulse READ_LAT cycles later. `rdata` then carries the register in bits 2:0 and zero in the higher bits.
- R9: Outside the mode, program and read commands have no effect: `busy` and `rdata_valid` stay low and the register is unchanged.
- R10: Inside the mode, a write with any data other than 0xA0 or 0x90 raises `hang`. After that, every access is ignored and `array_en` stays low until `rst_hw`.
- R11: `rst_hw` clears `hang` and `abort` and returns the block to normal operation with the register kept. `por` also clears the register.
- R12: Writes made while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, clears everything including the register |
| rst_hw | input | 1 | Hardware reset, synchronous, clears the command logic and keeps the register |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 12 | Bus address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Lock register read data |
| rdata_valid | output | 1 | One-cycle pulse marking `rdata` valid |
| array_en | output | 1 | Main array access enable |
| busy | output | 1 | Program operation in progress |
| abort | output | 1 | Last program request was refused |
| hang | output | 1 | Block hung by a non-command write in the mode |

## Verification
A wrong mode state shows on `array_en`, `busy` or `hang` on the first cycle after the write that caused it. A lost or wrongly set register bit only shows on the next register read, READ_LAT cycles after the strobe. For that reason, reads are placed after every program, abort, exit, hardware reset and power-on reset. A stuck unlock step or a lost abort shows at the next unlock attempt or program request, because the bench model compares all outputs every cycle.

// File: rtl/lk_pkg.sv
package lk_pkg;

    parameter int ADDR_W = 12;
    parameter int DATA_W = 8;

    localparam logic [ADDR_W-1:0] LK_ADDR_A = ADDR_W'(12'h555);
    localparam logic [ADDR_W-1:0] LK_ADDR_B = ADDR_W'(12'h2AA);
    localparam logic [DATA_W-1:0] LK_KEY_1  = 8'hAA;
    localparam logic [DATA_W-1:0] LK_KEY_2  = 8'h55;
    localparam logic [DATA_W-1:0] LK_KEY_3  = 8'h40;
    localparam logic [DATA_W-1:0] LK_CMD_PGM  = 8'hA0;
    localparam logic [DATA_W-1:0] LK_CMD_EXIT = 8'h90;

    typedef enum logic [2:0] {
        LK_NORMAL,
        LK_MODE,
        LK_PGM_DATA,
        LK_PROG,
        LK_HANG
    } lk_state_e;

    typedef struct packed {
        logic pw_lock;
        logic pers_lock;
        logic sec_prot;
    } lk_lock_t;

    function automatic logic lk_dual_lock(input lk_lock_t v);
        return v.pw_lock && v.pers_lock;
    endfunction

    function automatic lk_lock_t lk_from_data(input logic [DATA_W-1:0] d);
        return lk_lock_t'(d[2:0]);
    endfunction

endpackage

// File: rtl/lk_unlock_seq.sv
module lk_unlock_seq
    import lk_pkg::*;
(
    input  logic              clk,
    input  logic              clear,
    input  logic              arm,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              seq_done
);
    logic [1:0] step_q;
    logic       hit_first, hit_second, hit_third;

    always_comb begin
        hit_first  = (addr == LK_ADDR_A) && (data == LK_KEY_1);
        hit_second = (addr == LK_ADDR_B) && (data == LK_KEY_2);
        hit_third  = (addr == LK_ADDR_A) && (data == LK_KEY_3);
        seq_done   = arm && wr && (step_q == 2'd2) && hit_third;
    end

    always_ff @(posedge clk) begin
        if (clear || !arm) begin
            step_q <= 2'd0;
        end else if (wr) begin
            if (seq_done)
                step_q <= 2'd0;
            else if (step_q == 2'd1 && hit_second)
                step_q <= 2'd2;
            else if (hit_first)
                step_q <= 2'd1;
            else
                step_q <= 2'd0;
        end
    end

endmodule

// File: rtl/lk_otp_bits.sv
module lk_otp_bits
    import lk_pkg::*;
(
    input  logic     clk,
    input  logic     por,
    input  logic     set_en,
    input  lk_lock_t set_val,
    output lk_lock_t bits
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (por) begin
            bits    <= '0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (set_en)
                bits <= bits | set_val;
        end
    end

    // R5: a set bit never returns to zero outside power-on reset
    p_bits_monotonic_r5: assert property (@(posedge clk) disable iff (por)
        past_ok |-> ((bits & $past(bits)) == $past(bits)));

endmodule

// File: rtl/lk_read_delay.sv
module lk_read_delay
    import lk_pkg::*;
#(
    parameter int READ_LAT = 3
) (
    input  logic     clk,
    input  logic     clr,
    input  logic     start,
    input  lk_lock_t bits,
    output logic     pend,
    output logic     rvalid,
    output lk_lock_t rbits
);
    localparam int CW = (READ_LAT < 2) ? 1 : $clog2(READ_LAT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            pend   <= 1'b0;
            rvalid <= 1'b0;
            cnt_q  <= '0;
            rbits  <= '0;
        end else begin
            rvalid <= 1'b0;
            if (pend) begin
                if (cnt_q == '0) begin
                    pend   <= 1'b0;
                    rvalid <= 1'b1;
                    rbits  <= bits;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (start) begin
                pend  <= 1'b1;
                cnt_q <= CW'(READ_LAT - 1);
            end
        end
    end

    // R8: the valid marker is a single-cycle pulse
    p_rvalid_pulse_r8: assert property (@(posedge clk) disable iff (clr)
        rvalid |=> !rvalid);

endmodule

// File: rtl/lk_lockreg_cmd.sv
module lk_lockreg_cmd
    import lk_pkg::*;
#(
    parameter int PROG_CYCLES = 6,
    parameter int READ_LAT    = 3
) (
    input  logic              clk,
    input  logic              por,
    input  logic              rst_hw,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic              array_en,
    output logic              busy,
    output logic              abort,
    output logic              hang
);
    localparam int PW = (PROG_CYCLES < 2) ? 1 : $clog2(PROG_CYCLES);

    lk_state_e     state_q;
    logic [PW-1:0] pcnt_q;
    lk_lock_t      pend_q;
    logic          abort_q;
    logic          seq_done;
    logic          set_en;
    lk_lock_t      bits;
    lk_lock_t      rbits;
    logic          rd_pend;
    logic          rd_start;
    logic          rd_clr;
    logic          any_rst;
    lk_lock_t      wr_lock;

    always_comb begin
        any_rst  = por || rst_hw;
        wr_lock  = lk_from_data(wdata);
        set_en   = (state_q == LK_PROG) && (pcnt_q == '0);
        rd_start = (state_q == LK_MODE) && rd_en && !wr_en;
        rd_clr   = any_rst || ((state_q == LK_MODE) && wr_en && (wdata != LK_CMD_PGM));
        array_en = (state_q == LK_NORMAL);
        busy     = (state_q == LK_PROG);
        hang     = (state_q == LK_HANG);
        abort    = abort_q;
        rdata    = {{(DATA_W-3){1'b0}}, rbits};
    end

    lk_unlock_seq u_seq (
        .clk      (clk),
        .clear    (any_rst),
        .arm      (state_q == LK_NORMAL),
        .wr       (wr_en),
        .addr     (addr),
        .data     (wdata),
        .seq_done (seq_done)
    );

    lk_otp_bits u_otp (
        .clk     (clk),
        .por     (por),
        .set_en  (set_en),
        .set_val (pend_q),
        .bits    (bits)
    );

    lk_read_delay #(.READ_LAT(READ_LAT)) u_rd (
        .clk    (clk),
        .clr    (rd_clr),
        .start  (rd_start),
        .bits   (bits),
        .pend   (rd_pend),
        .rvalid (rdata_valid),
        .rbits  (rbits)
    );

    always_ff @(posedge clk) begin
        if (any_rst) begin
            state_q <= LK_NORMAL;
            pcnt_q  <= '0;
            pend_q  <= '0;
            abort_q <= 1'b0;
        end else begin
            unique case (state_q)
                LK_NORMAL: begin
                    if (seq_done) begin
                        state_q <= LK_MODE;
                        abort_q <= 1'b0;
                    end
                end
                LK_MODE: begin
                    if (wr_en) begin
                        if (wdata == LK_CMD_PGM) begin
                            state_q <= LK_PGM_DATA;
                            abort_q <= 1'b0;
                        end else if (wdata == LK_CMD_EXIT) begin
                            state_q <= LK_NORMAL;
                            abort_q <= 1'b0;
                        end else begin
                            state_q <= LK_HANG;
                        end
                    end
                end
                LK_PGM_DATA: begin
                    if (wr_en) begin
                        if (lk_dual_lock(wr_lock)) begin
                            abort_q <= 1'b1;
                            state_q <= LK_MODE;
                        end else begin
                            pend_q  <= wr_lock;
                            pcnt_q  <= PW'(PROG_CYCLES - 1);
                            state_q <= LK_PROG;
                        end
                    end
                end
                LK_PROG: begin
                    if (pcnt_q == '0)
                        state_q <= LK_MODE;
                    else
                        pcnt_q <= pcnt_q - 1'b1;
                end
                LK_HANG: state_q <= LK_HANG;
                default: state_q <= LK_NORMAL;
            endcase
        end
    end

    // R1: a completed unlock sequence closes the main array next cycle
    p_entry_gates_r1: assert property (@(posedge clk) disable iff (any_rst)
        ((state_q == LK_NORMAL) && seq_done) |=> !array_en);

    // R6: both mode locks in one request abort without programming
    p_dual_abort_r6: assert property (@(posedge clk) disable iff (any_rst)
        ((state_q == LK_PGM_DATA) && wr_en && wdata[1] && wdata[2]) |=> (abort && !busy));

    // R10: the hang persists and keeps the array closed
    p_hang_sticky_r10: assert property (@(posedge clk) disable iff (any_rst)
        hang |=> (hang && !array_en));

    // R2: programming never coincides with array access
    p_busy_gates_r2: assert property (@(posedge clk) disable iff (any_rst)
        busy |-> !array_en);

    // R12: a pending read is not started while programming
    p_no_read_in_prog_r12: assert property (@(posedge clk) disable iff (any_rst)
        (busy && !rd_pend) |=> !rd_pend);

endmodule

// File: tb/lk_lockreg_cmd_test.sv
`timescale 1ns/1ps
module lk_lockreg_cmd_test;

    localparam int PROG_CYCLES = 6;
    localparam int READ_LAT    = 3;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        rst_hw = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_valid, array_en, busy, abort, hang;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int last_rd = -1;

    // behavioural reference model
    int m_state = 0;   // 0 normal, 1 mode, 2 await data, 3 programming, 4 hung
    int m_step = 0, m_bits = 0, m_abort = 0, m_pcnt = 0, m_pv = 0;
    int m_rpend = 0, m_rcnt = 0, m_rv = 0, m_rd = 0;

    always #2 clk = ~clk;

    lk_lockreg_cmd #(.PROG_CYCLES(PROG_CYCLES), .READ_LAT(READ_LAT)) uut (
        .clk(clk), .por(por), .rst_hw(rst_hw), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_valid(rdata_valid),
        .array_en(array_en), .busy(busy), .abort(abort), .hang(hang)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit leave;
        if (por || rst_hw) begin
            if (por) m_bits = 0;
            m_state = 0; m_step = 0; m_abort = 0; m_pcnt = 0; m_pv = 0;
            m_rpend = 0; m_rcnt = 0; m_rv = 0; m_rd = 0;
        end else begin
            leave = (m_state == 1) && wr_en && (wdata != 8'hA0);
            m_rv = 0;
            if (leave) m_rpend = 0;
            else if (m_rpend == 1) begin
                if (m_rcnt == 0) begin m_rv = 1; m_rd = m_bits; m_rpend = 0; end
                else m_rcnt--;
            end else if (m_state == 1 && rd_en && !wr_en) begin
                m_rpend = 1; m_rcnt = READ_LAT - 1;
            end
            case (m_state)
                0: if (wr_en) begin
                    if (m_step == 2 && addr == 12'h555 && wdata == 8'h40) begin
                        m_state = 1; m_abort = 0; m_step = 0;
                    end else if (m_step == 1 && addr == 12'h2AA && wdata == 8'h55) m_step = 2;
                    else if (addr == 12'h555 && wdata == 8'hAA) m_step = 1;
                    else m_step = 0;
                end
                1: if (wr_en) begin
                    if (wdata == 8'hA0) begin m_state = 2; m_abort = 0; end
                    else if (wdata == 8'h90) begin m_state = 0; m_abort = 0; end
                    else m_state = 4;
                end
                2: if (wr_en) begin
                    if (wdata[1] && wdata[2]) begin m_abort = 1; m_state = 1; end
                    else begin m_state = 3; m_pcnt = PROG_CYCLES - 1; m_pv = int'(wdata[2:0]); end
                end
                3: if (m_pcnt == 0) begin m_bits = m_bits | m_pv; m_state = 1; end
                   else m_pcnt--;
                default: ;
            endcase
        end
    end

    always @(negedge clk) begin
        cycles++;
        chk("R2 array_en", int'(array_en), int'(m_state == 0));
        chk("R4 busy", int'(busy), int'(m_state == 3));
        chk("R7 abort", int'(abort), m_abort);
        chk("R10 hang", int'(hang), int'(m_state == 4));
        chk("R8 rdata_valid", int'(rdata_valid), m_rv);
        if (m_rv == 1) chk("R8 rdata", int'(rdata), m_rd);
        if (rdata_valid) last_rd = int'(rdata);
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd_reg();
        last_rd = -1;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        idle(READ_LAT + 1);
    endtask

    task automatic enter();
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h40);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        por = 1'b0;
        chk("R11 reset array_en", int'(array_en), 1);
        chk("R11 reset abort", int'(abort), 0);
        // R9: commands outside the mode
        wr(12'h000, 8'hA0); wr(12'h000, 8'h01);
        chk("R9 busy outside mode", int'(busy), 0);
        rd_reg();
        chk("R9 no read outside mode", last_rd, -1);
        // R1: broken sequence
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h56); wr(12'h555, 8'h40);
        chk("R1 broken sequence keeps array", int'(array_en), 1);
        enter();
        chk("R1 mode entered", int'(array_en), 0);
        rd_reg();
        chk("R9 register untouched", last_rd, 0);
        // R4 program secure-sector bit, R12 write during busy ignored
        wr(12'h000, 8'hA0); wr(12'h000, 8'h01);
        chk("R4 busy after data", int'(busy), 1);
        wr(12'h000, 8'h90);
        idle(PROG_CYCLES);
        chk("R12 exit during busy ignored", int'(array_en), 0);
        rd_reg();
        chk("R4 sec bit set", last_rd, 1);
        // R6 dual lock abort, R7 held
        wr(12'h000, 8'hA0); wr(12'h000, 8'h06);
        chk("R6 abort raised", int'(abort), 1);
        chk("R6 no busy", int'(busy), 0);
        rd_reg();
        chk("R6 register unchanged", last_rd, 1);
        chk("R7 abort held over read", int'(abort), 1);
        wr(12'h000, 8'hA0);
        chk("R7 abort cleared by command", int'(abort), 0);
        wr(12'h000, 8'h02);
        idle(PROG_CYCLES);
        rd_reg();
        chk("R4 persistent bit set", last_rd, 3);
        // R5 zero does not clear
        wr(12'h000, 8'hA0); wr(12'h000, 8'h00);
        idle(PROG_CYCLES);
        rd_reg();
        chk("R5 bits stay set", last_rd, 3);
        // R3 exit
        wr(12'h000, 8'h90);
        chk("R3 array reopened", int'(array_en), 1);
        // R10 hang
        enter();
        wr(12'h123, 8'h33);
        chk("R10 hang raised", int'(hang), 1);
        wr(12'h000, 8'h90);
        enter();
        chk("R10 hang ignores exit and entry", int'(array_en), 0);
        // R11 hardware reset keeps bits
        rst_hw = 1'b1; @(negedge clk); rst_hw = 1'b0;
        chk("R11 rst_hw clears hang", int'(hang), 0);
        chk("R11 rst_hw reopens array", int'(array_en), 1);
        enter();
        rd_reg();
        chk("R11 bits kept over rst_hw", last_rd, 3);
        wr(12'h000, 8'hA0); wr(12'h000, 8'h04);
        idle(PROG_CYCLES);
        rd_reg();
        chk("R4 password bit set", last_rd, 7);
        wr(12'h000, 8'h90);
        por = 1'b1; @(negedge clk); por = 1'b0;
        enter();
        rd_reg();
        chk("R11 por clears bits", last_rd, 0);
        wr(12'h000, 8'h90);
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule